// File: doc/BRIEF.md
# Two-Channel Serial-Controlled Wiper Register Block

This block is the digital front end of a dual 8-bit digital potentiometer. It listens on a two-wire serial bus (I2C-style START, STOP, 8-bit bytes sent MSB first, and a ninth acknowledge clock). It answers to one 7-bit device address. The two low bits of that address come from strap pins, so four such blocks can share a bus.

A write carries a command byte and then a data byte. The command byte picks a channel, may force that channel's wiper to the centre code, sets or clears that channel's power-down flag, and drives two spare logic outputs. The data byte is then loaded into the chosen wiper. A read returns one byte straight after the address acknowledge: the wiper code of the channel named by the last command.

Both bus lines are brought into the system clock domain through two-flop synchronizers, and the block drives SDA only by pulling it low. The analog ladder, clock stretching, general-call and 10-bit addressing are outside the block.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset, both wiper codes are 0x80, both power-down outputs are low, both spare outputs are low, and SDA is released (sda_pull = 0).
- R2: The device address is {5'b01011, addr_sel[1:0]}. On a match the block pulls SDA low during the ninth clock of the address byte and of every written byte after it. On a mismatch it never pulls SDA, and the rest of the transfer up to the next START or STOP changes nothing.
- R3: In a write (R/W bit = 0), the byte after the command byte is loaded into the wiper selected by command bit 7 (0 = channel 1 on wiper_1, 1 = channel 2 on wiper_2). The other wiper keeps its code.
- R4: Command bit 6 = 1 sets the selected wiper to 0x80. A data byte in the same write then overwrites it, and a STOP right after the command byte leaves 0x80 in place.
- R5: Command bit 5 sets the selected channel's power-down flag when 1 and clears it when 0; off_1/off_2 show the flags. The other channel's flag is unchanged.
- R6: Command bits 4 and 3 are copied to spare_2 and spare_1. Command bits 2 to 0 have no effect on any output.
- R7: In a read (R/W bit = 1), the block sends, MSB first, the code of the wiper named by bit 7 of the last command byte. Before any command this is channel 1. The block then releases SDA for the master's not-acknowledge.
- R8: While shdn_n is low, off_1 and off_2 are both high, whatever the stored flags are.
- R9: A repeated START at any point restarts address decoding. This holds even after an address mismatch.
- R10: The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| addr_sel | input | 2 | Low two bits of the device address |
| shdn_n | input | 1 | Active-low power-down pin for both channels |
| wiper_1 | output | 8 | Channel 1 wiper code |
| wiper_2 | output | 8 | Channel 2 wiper code |
| off_1 | output | 1 | Channel 1 powered down |
| off_2 | output | 1 | Channel 2 powered down |
| spare_1 | output | 1 | Spare logic output from command bit 3 |
| spare_2 | output | 1 | Spare logic output from command bit 4 |

## Verification
The assertions assume a well-behaved master. It moves SDA only while SCL is low. It never issues a START or STOP while the slave is pulling SDA. It holds each SCL phase long enough for the synchronizer delay to settle before the next edge. The bench master keeps SCL low for two quarter-periods of 4 system clocks each and changes SDA one quarter after each falling edge. It issues STOP or a repeated START only after the slave has released SDA, at the end of an acknowledge or after the not-acknowledge. Random stimulus varies the address, command, data, transfer type and truncation point inside those timing rules.

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
  parameter logic [4:0] BASE_ADDR = 5'b01011,
  parameter logic [7:0] MID_CODE  = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic [1:0] addr_sel,
  input  logic       shdn_n,
  output logic [7:0] wiper_1,
  output logic [7:0] wiper_2,
  output logic       off_1,
  output logic       off_2,
  output logic       spare_1,
  output logic       spare_2
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_READ, S_SKIP} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       ackph, sel;
  logic [1:0] pd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_v = scl_q[1], sda_v = sda_q[1];
  wire scl_p = scl_q[2], sda_p = sda_q[2];
  wire start_c = scl_v & scl_p & sda_p & ~sda_v;
  wire stop_c  = scl_v & scl_p & ~sda_p & sda_v;
  wire rise    = scl_v & ~scl_p;
  wire fall    = ~scl_v & scl_p;
  wire [7:0] rd_code = sel ? wiper_2 : wiper_1;
  wire receiving = (st == S_ADDR) || (st == S_CMD) || (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ackph <= 1'b0; sda_pull <= 1'b0;
      sel <= 1'b0; pd <= '0; spare_1 <= 1'b0; spare_2 <= 1'b0;
      wiper_1 <= MID_CODE; wiper_2 <= MID_CODE;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; ackph <= 1'b0; sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ackph <= 1'b0; sda_pull <= 1'b0;
    end else if (rise && !ackph && cnt < 4'd8 && (receiving || st == S_READ)) begin
      cnt <= cnt + 4'd1;
      if (receiving) sh <= {sh[6:0], sda_v};
    end else if (fall) begin
      if (ackph) begin
        ackph <= 1'b0; cnt <= '0; sda_pull <= 1'b0;
        case (st)
          S_ADDR:
            if (sh[0]) begin
              st <= S_READ; sh <= rd_code; sda_pull <= ~rd_code[7];
            end else st <= S_CMD;
          S_CMD:   st <= S_DATA;
          default: st <= S_SKIP;
        endcase
      end else if (st == S_READ) begin
        if (cnt == 4'd8) begin
          sda_pull <= 1'b0; st <= S_SKIP;
        end else if (cnt != 4'd0) begin
          sh <= {sh[6:0], 1'b0}; sda_pull <= ~sh[6];
        end
      end else if (cnt == 4'd8) begin
        case (st)
          S_ADDR:
            if (sh[7:1] == {BASE_ADDR, addr_sel}) begin
              ackph <= 1'b1; sda_pull <= 1'b1;
            end else st <= S_SKIP;
          S_CMD: begin
            ackph <= 1'b1; sda_pull <= 1'b1;
            sel <= sh[7]; spare_2 <= sh[4]; spare_1 <= sh[3];
            pd[sh[7]] <= sh[5];
            if (sh[6]) begin
              if (sh[7]) wiper_2 <= MID_CODE;
              else       wiper_1 <= MID_CODE;
            end
          end
          S_DATA: begin
            ackph <= 1'b1; sda_pull <= 1'b1;
            if (sel) wiper_2 <= sh;
            else     wiper_1 <= sh;
          end
          default: ;
        endcase
      end
    end

  assign off_1 = pd[0] | ~shdn_n;
  assign off_2 = pd[1] | ~shdn_n;

  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_pull) |-> !scl_v);
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_SKIP) |-> !sda_pull);
  p_wiper_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed({wiper_1, wiper_2}) |-> $past(fall));
  p_flag_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pd) |-> $past(fall));
  p_spare_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $changed({spare_1, spare_2}) |-> $past(fall));
endmodule

// File: tb/sim_dpot_i2c_slave.sv
module sim_dpot_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [1:0] PINS = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, shdn_n = 1'b1;
  logic sda_pull, off_1, off_2, spare_1, spare_2;
  logic [7:0] wiper_1, wiper_2;
  wire sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .addr_sel(PINS), .shdn_n(shdn_n), .wiper_1(wiper_1), .wiper_2(wiper_2),
    .off_1(off_1), .off_2(off_2), .spare_1(spare_1), .spare_2(spare_2));

  int total = 0, bad = 0, viol = 0;
  logic [7:0] m_w [2];
  logic [1:0] m_pd;
  logic m_sel, m_s1, m_s2;

  function automatic bit hit(input logic [6:0] a);
    return a == {5'b01011, PINS};
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    return hit(a) ? m_w[m_sel] : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic bus_start; sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq; endtask
  task automatic bus_stop; sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq; endtask
  task automatic wr_bit(input logic b); sda_m = b; wq; scl_m = 1; wq; wq; scl_m = 0; wq; endtask
  task automatic rd_bit(output logic b);
    sda_m = 1; wq; scl_m = 1; wq; b = sda_line; wq; scl_m = 0; wq;
  endtask
  task automatic wr_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(ack);
  endtask
  task automatic rd_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rd_bit(v[i]);
  endtask

  function automatic void apply_cmd(input logic [7:0] c);
    m_sel = c[7]; m_s2 = c[4]; m_s1 = c[3]; m_pd[c[7]] = c[5];
    if (c[6]) m_w[c[7]] = 8'h80;
  endfunction

  task automatic do_write(input string req, input logic [6:0] a, input logic [7:0] c,
                          input logic [7:0] d, input int nb);
    logic ack;
    bus_start;
    wr_byte({a, 1'b0}, ack);
    chk({req, "/R2 addr ack"}, ack, !hit(a));
    if (nb >= 1) begin
      wr_byte(c, ack);
      chk({req, "/R2 cmd ack"}, ack, !hit(a));
      if (hit(a)) apply_cmd(c);
    end
    if (nb >= 2) begin
      wr_byte(d, ack);
      chk({req, "/R2 data ack"}, ack, !hit(a));
      if (hit(a)) m_w[m_sel] = d;
    end
    bus_stop;
  endtask

  task automatic do_read(input string req, input logic [6:0] a);
    logic ack; logic [7:0] v;
    bus_start;
    wr_byte({a, 1'b1}, ack);
    chk({req, "/R2 read addr ack"}, ack, !hit(a));
    rd_byte(v);
    wr_bit(1'b1);
    bus_stop;
    chk({req, "/R7 read data"}, v, exp_read(a));
  endtask

  task automatic check_outs(input string req);
    chk({req, " wiper_1"}, wiper_1, m_w[0]);
    chk({req, " wiper_2"}, wiper_2, m_w[1]);
    chk({req, " off"}, {off_2, off_1}, shdn_n ? m_pd : 2'b11);
    chk({req, " spare"}, {spare_2, spare_1}, {m_s2, m_s1});
  endtask

  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && sda_pull !== pull_prev) viol++;
    pull_prev = sda_pull;
  end

  localparam logic [6:0] ME = {5'b01011, PINS};

  initial begin
    logic ack;
    m_w[0] = 8'h80; m_w[1] = 8'h80; m_pd = 0; m_sel = 0; m_s1 = 0; m_s2 = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_outs("R1 reset");
    chk("R1 sda released", sda_pull, 0);

    do_read("R7 default ch1", ME);
    do_write("R3 ch1 load", ME, 8'h00, 8'h3C, 2); check_outs("R3 ch1 load");
    do_write("R3 ch2 load", ME, 8'h80, 8'hA5, 2); check_outs("R3 ch2 load");
    do_read("R7 last sel ch2", ME);
    do_write("R2 mismatch", 7'h2F, 8'h40, 8'h00, 2); check_outs("R2 mismatch no change");
    do_read("R2 mismatch read", 7'h2C);
    do_write("R4 mid then data", ME, 8'h40, 8'h11, 2); check_outs("R4 mid then data");
    do_write("R4 mid then stop", ME, 8'hC0, 8'h00, 1); check_outs("R4 mid then stop");
    do_write("R5 pd ch1", ME, 8'h20, 8'h55, 2); check_outs("R5 pd ch1");
    do_write("R5 pd ch2", ME, 8'hA0, 8'h66, 2); check_outs("R5 pd ch2");
    do_write("R5 clear ch1", ME, 8'h00, 8'h55, 2); check_outs("R5 clear ch1");
    do_write("R6 spares+ignored", ME, 8'h1F, 8'h77, 2); check_outs("R6 spares+ignored");
    do_write("R6 spare2 only", ME, 8'h10, 8'h78, 2); check_outs("R6 spare2 only");
    shdn_n = 0; repeat (2) @(negedge clk); check_outs("R8 pin low");
    shdn_n = 1; repeat (2) @(negedge clk); check_outs("R8 pin released");

    // R9: mismatch, repeated START, then own write
    bus_start; wr_byte({7'h2D, 1'b0}, ack); chk("R9 miss no ack", ack, 1);
    wr_byte(8'h80, ack);
    bus_start; wr_byte({ME, 1'b0}, ack); chk("R9 rstart addr ack", ack, 0);
    wr_byte(8'h80, ack); apply_cmd(8'h80);
    wr_byte(8'h5A, ack); m_w[1] = 8'h5A;
    bus_stop; check_outs("R9 after rstart");
    // R9: command then repeated START into a read
    bus_start; wr_byte({ME, 1'b0}, ack); wr_byte(8'h00, ack); apply_cmd(8'h00);
    bus_start; wr_byte({ME, 1'b1}, ack); chk("R9 rstart read ack", ack, 0);
    begin
      logic [7:0] v;
      rd_byte(v); wr_bit(1'b1); bus_stop;
      chk("R9/R7 rstart read data", v, m_w[0]);
    end

    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      logic [6:0] a; logic [7:0] c, d; int nb;
      a = ($urandom % 4 == 0) ? {5'b01011, 2'($urandom)} : ME;
      if ($urandom % 8 == 0) a = 7'($urandom);
      c = 8'($urandom); d = 8'($urandom); nb = $urandom % 3;
      if ($urandom % 3 == 0) do_read("rand R7", a);
      else begin
        do_write("rand R3", a, c, d, nb);
        check_outs("rand R3/R4/R5/R6");
      end
    end

    chk("R10 pull changes only with SCL low", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule